// File: doc/BRIEF.md
# Differential ADC Serial Read Controller

This block is the host side of a link to a three-wire serial sampling converter. From the system clock it makes a serial clock with an enable-based divider and produces the convert strobe. It captures the returned bits on falling serial-clock edges and delivers each result as a sign-extended parallel sample with a one-cycle valid strobe. Resolution (12 or 14 bits), frame length (16 or 18 serial clocks) and the divide ratio are parameters.

A frame starts when the convert strobe rises, half a serial-clock period before the first rising serial-clock edge. The strobe stays high for one serial-clock period. Result bits arrive MSB first from the third rising edge on. Each frame returns the conversion launched by the previous strobe, so the first sample after idle is stale. Between frames the block can also issue power commands to the converter. Nap is two convert pulses with the serial clock held low. Sleep is four such pulses. Wake is a single serial-clock pulse with the convert strobe low.

Top module: `adc_serial_host`

## Requirements
- R1: While reset is asserted and right after it is released, sck_o, conv_o, valid_o and busy_o are all low.
- R2: A frame or power command raises conv_o while sck_o is low. A frame's conv_o pulse lasts exactly SCK_DIV system cycles. The first rising sck_o edge of a frame comes SCK_DIV/2 cycles after conv_o rises.
- R3: sck_o has a period of SCK_DIV cycles and stays high for SCK_DIV/2 cycles. A frame has exactly FRAME_CLKS rising sck_o edges and one conv_o pulse.
- R4: sdo_i is sampled on the falling sck_o edge that follows each of rising edges 3 through 2+RES_BITS of the frame. The first bit sampled is the MSB.
- R5: Levels on sdo_i during rising edges 1, 2 and above 2+RES_BITS do not affect the sample. In 12-bit mode this covers the two positions after the LSB.
- R6: The captured word is two's complement. It appears on sample_o sign-extended to OUT_W bits, with valid_o high for exactly one cycle. valid_o rises together with the falling sck_o edge that captures the last bit.
- R7: A nap request produces two conv_o pulses, each SCK_DIV cycles high with SCK_DIV cycles low after it, and no sck_o edge.
- R8: A sleep request produces four conv_o pulses of the same shape, and no sck_o edge.
- R9: A wake request produces one sck_o pulse, SCK_DIV/2 cycles high, with conv_o held low.
- R10: busy_o is high from the cycle after a request is accepted until the frame or command ends. Requests are accepted only while busy_o is low. A request made while busy_o is high has no effect.
- R11: When several requests arrive in the same idle cycle, the order of precedence is sleep, then nap, then wake, then frame start. The others are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one conversion frame |
| nap_req_i | input | 1 | Request the nap command |
| sleep_req_i | input | 1 | Request the sleep command |
| wake_req_i | input | 1 | Request the wake pulse |
| sdo_i | input | 1 | Serial data from the converter |
| sck_o | output | 1 | Serial clock to the converter |
| conv_o | output | 1 | Convert strobe to the converter |
| sample_o | output | OUT_W | Sign-extended result |
| valid_o | output | 1 | One-cycle strobe for sample_o |
| busy_o | output | 1 | Frame or command in progress |

## Verification
The assertions assume that sdo_i changes only after a rising sck_o edge and is stable at the following falling edge. They also assume that FRAME_CLKS is at least RES_BITS+2 and SCK_DIV is at least 2. The bench converter model updates sdo_i only on rising sck_o edges, from the word queued for that frame. It drives the opposite of the sign bit on every non-data edge, so a stray capture would show in the sample. Requests come as single-cycle pulses, either from idle or deliberately in the middle of a frame.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FRAME,
    ST_CMD,
    ST_WAKE
  } seq_state_e;

  localparam int NAP_PULSES   = 2;
  localparam int SLEEP_PULSES = 4;
  localparam int FIRST_BIT    = 3;  // rising edge carrying the MSB
endpackage

// File: rtl/sck_div.sv
module sck_div #(
  parameter int SCK_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int CW   = (SCK_DIV > 2) ? $clog2(SCK_DIV) : 1;
  localparam int HALF = SCK_DIV / 2;

  logic [CW-1:0] cnt_q;

  // idle parks in the low phase so the first rise lands HALF cycles after start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= CW'(HALF);
    else if (!run_i)                     cnt_q <= CW'(HALF);
    else if (cnt_q == CW'(SCK_DIV - 1))  cnt_q <= '0;
    else                                 cnt_q <= cnt_q + CW'(1);
  end

  assign rise_o = run_i && (cnt_q == CW'(SCK_DIV - 1));
  assign fall_o = run_i && (cnt_q == CW'(HALF - 1));
endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_host_pkg::*;
#(
  parameter int RES_BITS   = 14,
  parameter int FRAME_CLKS = 18
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic nap_req_i,
  input  logic sleep_req_i,
  input  logic wake_req_i,
  input  logic rise_i,
  input  logic fall_i,
  output logic run_o,
  output logic sck_o,
  output logic conv_o,
  output logic busy_o,
  output logic cap_en_o,
  output logic cap_last_o
);
  localparam int EW       = $clog2(FRAME_CLKS + 1);
  localparam int TW       = $clog2(2 * SLEEP_PULSES + 1);
  localparam int LAST_BIT = FIRST_BIT + RES_BITS - 1;

  seq_state_e    state_q;
  logic          sck_q, conv_q;
  logic [EW-1:0] edge_q;
  logic [TW-1:0] tgl_q, lim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sck_q   <= 1'b0;
      conv_q  <= 1'b0;
      edge_q  <= '0;
      tgl_q   <= '0;
      lim_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          edge_q <= '0;
          tgl_q  <= '0;
          if (sleep_req_i) begin
            state_q <= ST_CMD;
            lim_q   <= TW'(2 * SLEEP_PULSES);
            conv_q  <= 1'b1;
          end else if (nap_req_i) begin
            state_q <= ST_CMD;
            lim_q   <= TW'(2 * NAP_PULSES);
            conv_q  <= 1'b1;
          end else if (wake_req_i) begin
            state_q <= ST_WAKE;
          end else if (start_i) begin
            state_q <= ST_FRAME;
            conv_q  <= 1'b1;
          end
        end
        ST_FRAME: begin
          if (rise_i) begin
            sck_q  <= 1'b1;
            edge_q <= edge_q + EW'(1);
          end
          if (fall_i) begin
            sck_q <= 1'b0;
            if (edge_q == EW'(1))          conv_q  <= 1'b0;
            if (edge_q == EW'(FRAME_CLKS)) state_q <= ST_IDLE;
          end
        end
        ST_CMD: begin
          // every fall tick toggles conv; the last one closes the low gap
          if (fall_i) begin
            tgl_q <= tgl_q + TW'(1);
            if (tgl_q + TW'(1) == lim_q) begin
              conv_q  <= 1'b0;
              state_q <= ST_IDLE;
            end else begin
              conv_q <= ~conv_q;
            end
          end
        end
        ST_WAKE: begin
          if (rise_i) sck_q <= 1'b1;
          if (fall_i) begin
            sck_q   <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign run_o      = (state_q != ST_IDLE);
  assign busy_o     = run_o;
  assign sck_o      = sck_q;
  assign conv_o     = conv_q;
  assign cap_en_o   = (state_q == ST_FRAME) && fall_i &&
                      (edge_q >= EW'(FIRST_BIT)) && (edge_q <= EW'(LAST_BIT));
  assign cap_last_o = cap_en_o && (edge_q == EW'(LAST_BIT));

  // R3
  frame_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FRAME) |-> (edge_q <= EW'(FRAME_CLKS)));
  // R7
  cmd_sck_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_CMD) |-> !sck_q);
  // R9
  wake_conv_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAKE) |-> !conv_q);
  // R10
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!sck_q && !conv_q));
endmodule

// File: rtl/adc_capture.sv
module adc_capture #(
  parameter int RES_BITS = 14,
  parameter int OUT_W    = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cap_en_i,
  input  logic             cap_last_i,
  input  logic             sdo_i,
  output logic [OUT_W-1:0] sample_o,
  output logic             valid_o
);
  logic [RES_BITS-1:0] shift_q;
  logic [RES_BITS-1:0] word;
  logic [OUT_W-1:0]    sample_q;
  logic                valid_q;

  assign word = {shift_q[RES_BITS-2:0], sdo_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q  <= '0;
      sample_q <= '0;
      valid_q  <= 1'b0;
    end else begin
      valid_q <= cap_en_i && cap_last_i;
      if (cap_en_i) shift_q <= word;
      if (cap_en_i && cap_last_i) sample_q <= OUT_W'($signed(word));
    end
  end

  assign sample_o = sample_q;
  assign valid_o  = valid_q;

  // R6
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
endmodule

// File: rtl/adc_serial_host.sv
module adc_serial_host #(
  parameter int RES_BITS   = 14,
  parameter int FRAME_CLKS = 18,
  parameter int SCK_DIV    = 4,
  parameter int OUT_W      = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             nap_req_i,
  input  logic             sleep_req_i,
  input  logic             wake_req_i,
  input  logic             sdo_i,
  output logic             sck_o,
  output logic             conv_o,
  output logic [OUT_W-1:0] sample_o,
  output logic             valid_o,
  output logic             busy_o
);
  logic run, rise, fall, cap_en, cap_last;

  sck_div #(.SCK_DIV(SCK_DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .rise_o (rise),
    .fall_o (fall)
  );

  adc_seq #(.RES_BITS(RES_BITS), .FRAME_CLKS(FRAME_CLKS)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .nap_req_i   (nap_req_i),
    .sleep_req_i (sleep_req_i),
    .wake_req_i  (wake_req_i),
    .rise_i      (rise),
    .fall_i      (fall),
    .run_o       (run),
    .sck_o       (sck_o),
    .conv_o      (conv_o),
    .busy_o      (busy_o),
    .cap_en_o    (cap_en),
    .cap_last_o  (cap_last)
  );

  adc_capture #(.RES_BITS(RES_BITS), .OUT_W(OUT_W)) u_cap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cap_en_i   (cap_en),
    .cap_last_i (cap_last),
    .sdo_i      (sdo_i),
    .sample_o   (sample_o),
    .valid_o    (valid_o)
  );

  // R2
  conv_sck_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conv_o) |-> !sck_o);
endmodule

// File: tb/adc_serial_host_tb_top.sv
module adc_serial_host_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int QTR        = CLK_PERIOD / 4;
  localparam int RES        = 12;
  localparam int FRM        = 18;
  localparam int DIV        = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, nap = 1'b0, slp = 1'b0, wak = 1'b0, sdo = 1'b0;
  logic sck, conv, valid, busy;
  logic [15:0] sample;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_serial_host #(.RES_BITS(RES), .FRAME_CLKS(FRM), .SCK_DIV(DIV), .OUT_W(16)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .nap_req_i(nap),
    .sleep_req_i(slp), .wake_req_i(wak), .sdo_i(sdo), .sck_o(sck),
    .conv_o(conv), .sample_o(sample), .valid_o(valid), .busy_o(busy)
  );

  int n_cmp = 0, n_bad = 0;
  logic [15:0] exp_q[$];

  task automatic chk_eq(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // converter model: bits change only on rising sck
  logic [RES-1:0] tx_word = '0;
  int m_edge = 0;
  always @(posedge sck) begin
    if (conv) m_edge = 1;
    else      m_edge = m_edge + 1;
    if (m_edge >= 3 && m_edge <= 2 + RES) sdo = tx_word[RES - 1 - (m_edge - 3)];
    else                                  sdo = ~tx_word[RES-1];  // junk, R5
  end

  // monitor / scoreboard, sampled mid-cycle
  int cyc = 0, conv_rise_cyc = 0, sck_rise_cyc = 0;
  int conv_pulses = 0, total_rises = 0, rises_since_conv = 0, n_valid = 0;
  bit pend_first = 0;
  logic p_sck = 0, p_conv = 0, p_valid = 0;
  always @(negedge clk) if (rst_n) begin
    cyc++;
    if (conv && !p_conv) begin
      conv_rise_cyc = cyc; conv_pulses++; pend_first = 1; rises_since_conv = 0;
    end
    if (!conv && p_conv) chk_eq("R2 conv pulse width", cyc - conv_rise_cyc, DIV);
    if (sck && !p_sck) begin
      total_rises++; rises_since_conv++; sck_rise_cyc = cyc;
      if (pend_first) begin
        chk_eq("R2 conv to first sck rise", cyc - conv_rise_cyc, DIV/2);
        pend_first = 0;
      end
    end
    if (!sck && p_sck) chk_eq("R3 sck high time", cyc - sck_rise_cyc, DIV/2);
    if (valid) begin
      n_valid++;
      chk_eq("R4 valid at capture of last bit", rises_since_conv, 2 + RES);
      chk_eq("R6 valid with falling sck", int'(p_sck && !sck), 1);
      chk_eq("R6 valid single cycle", int'(p_valid), 0);
      if (exp_q.size() == 0) chk_eq("R6 unexpected valid", 1, 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk_eq("R6 sample value", int'(sample), int'(e));
      end
    end
    if (!busy) pend_first = 0;
    p_sck = sck; p_conv = conv; p_valid = valid;
  end

  task automatic step();
    @(posedge clk); #QTR;
  endtask

  task automatic run_frame(input logic [RES-1:0] w);
    int r0, c0;
    r0 = total_rises; c0 = conv_pulses;
    exp_q.push_back(16'($signed(w)));
    tx_word = w;
    start = 1'b1; step(); start = 1'b0;
    chk_eq("R10 busy after start", int'(busy), 1);
    while (busy) step();
    step(); step();
    chk_eq("R3 rising edges per frame", total_rises - r0, FRM);
    chk_eq("R3 one conv pulse per frame", conv_pulses - c0, 1);
  endtask

  task automatic run_req(input bit s, input bit n, input bit w, input bit st,
                         input int ep, input int er, input string tag);
    int r0, c0, v0;
    r0 = total_rises; c0 = conv_pulses; v0 = n_valid;
    slp = s; nap = n; wak = w; start = st;
    step();
    slp = 0; nap = 0; wak = 0; start = 0;
    chk_eq({tag, " busy"}, int'(busy), 1);
    while (busy) step();
    step(); step();
    chk_eq({tag, " conv pulses"}, conv_pulses - c0, ep);
    chk_eq({tag, " sck rises"}, total_rises - r0, er);
    chk_eq({tag, " no sample"}, n_valid - v0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_bad++;
    $display("FAIL watchdog timeout: actual 1 expected 0");
    summary();
    $finish;
  end

  initial begin
    repeat (3) step();
    // R1
    chk_eq("R1 sck in reset", int'(sck), 0);
    chk_eq("R1 conv in reset", int'(conv), 0);
    chk_eq("R1 valid in reset", int'(valid), 0);
    chk_eq("R1 busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    step(); step();
    chk_eq("R1 quiet after reset", int'(sck | conv | valid | busy), 0);

    // R4 R5 R6: value patterns incl. extremes of two's complement
    run_frame(12'h7FF);
    run_frame(12'h800);
    run_frame(12'h000);
    run_frame(12'hFFF);
    run_frame(12'h5A3);
    run_frame(12'hA5C);
    run_frame(12'h001);

    // R7 nap, R8 sleep, R9 wake
    run_req(0, 1, 0, 0, 2, 0, "R7 nap");
    run_req(1, 0, 0, 0, 4, 0, "R8 sleep");
    run_req(0, 0, 1, 0, 0, 1, "R9 wake");
    run_frame(12'h3C5);

    // R11 precedence
    run_req(1, 1, 1, 1, 4, 0, "R11 sleep wins");
    run_req(0, 1, 1, 1, 2, 0, "R11 nap over wake");
    run_req(0, 0, 1, 1, 0, 1, "R11 wake over start");

    // R10 requests during a frame are dropped
    begin
      int c0, seen;
      c0 = conv_pulses; seen = 0;
      exp_q.push_back(16'($signed(12'hC3A)));
      tx_word = 12'hC3A;
      start = 1'b1; step(); start = 1'b0;
      repeat (20) step();
      slp = 1'b1; nap = 1'b1; wak = 1'b1; start = 1'b1; step();
      slp = 1'b0; nap = 1'b0; wak = 1'b0; start = 1'b0;
      while (busy) step();
      repeat (4 * DIV) begin
        step();
        if (busy || conv || sck) seen++;
      end
      chk_eq("R10 request during frame ignored", seen, 0);
      chk_eq("R10 single conv pulse", conv_pulses - c0, 1);
    end

    run_frame(12'h801);
    chk_eq("R6 all samples delivered", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule